// File: doc/BRIEF.md
# Timed Privilege Unlock Gate

This block stands between a CPU and two kinds of privileged action. The first kind is writes to guarded control registers. The second is strobes that launch flash-programming operations. Neither kind goes through on its own. Software first writes one of two signature bytes into a key register. Each signature opens a short window for its own kind of action. While the window is open, interrupt requests to the CPU are held off so that the unlock sequence cannot be split by a handler.

The gate produces per-cycle enables. A guarded register write, or a program strobe, is passed on only in a cycle where a window of the matching kind is open. The first action that gets through shuts the window. Writing a new signature while a window is open starts the count again with the new kind.

The gate also keeps a lock flag. Setting it is itself a guarded register write. Once it is set, no later program strobe is passed on, and only reset clears it.

Top module: `prot_gate`

## Requirements
- R1: After reset no window is open, `pgm_locked` is 0, no enable is given for any request, and `irq_out` follows `irq_in`.
- R2: A key write of 0xD8 opens a register-write window that starts in the cycle after the key write. While it is open, `prot_wr_req` is passed to `prot_wr_en` in the same cycle.
- R3: A key write of 0x9D opens a program window that starts in the cycle after the key write. While it is open, `pgm_req` is passed to `pgm_en` in the same cycle.
- R4: A window stays open for exactly 4 cycles after the key write. A request in the 5th cycle or later is dropped.
- R5: A request with no window open, or with a window of the other kind open, is dropped.
- R6: `irq_out` is 0 in every cycle a window is open and equals `irq_in` otherwise.
- R7: A lock write with `lock_wr_val`=1 inside a register-write window sets `pgm_locked` from the next cycle. The same write outside such a window leaves the flag clear.
- R8: While `pgm_locked` is 1, `pgm_en` stays 0 even inside a program window.
- R9: Only reset clears `pgm_locked`. A lock write with `lock_wr_val`=0 changes nothing and does not close the window.
- R10: A signature key write while a window is open reloads the 4-cycle count and takes the new window kind.
- R11: An accepted action closes the window from the next cycle: an enabled register write, a lock set, or an enabled program strobe.
- R12: A key write of any value other than the two signatures opens no window and leaves an open window's count running as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_we | input | 1 | Write strobe for the key register |
| key_wdata | input | 8 | Byte written to the key register |
| prot_wr_req | input | 1 | Request to write a guarded control register |
| lock_wr_req | input | 1 | Request to write the program-lock flag |
| lock_wr_val | input | 1 | Value carried by the lock write |
| pgm_req | input | 1 | Program-operation strobe from the CPU |
| irq_in | input | 1 | Interrupt request toward the CPU |
| prot_wr_en | output | 1 | Guarded register write accepted this cycle |
| pgm_en | output | 1 | Program operation accepted this cycle |
| irq_out | output | 1 | Interrupt request after masking |
| pgm_locked | output | 1 | Sticky program-lock flag |

## Verification
The bench sends requests at several points relative to a key write:
- In the key cycle itself, in the first and last open cycles, and one cycle after expiry. These pin down where the window starts and how long it lasts.
- Of the matching and the opposite kind, to separate the two privileges.
- Twice in a row, to show that the first acceptance closes the window.

Keys are also written mid-window, both signatures and a non-signature byte. The irq mask and the expiry point then show whether the count was reloaded or left running. The lock flag is driven with both values, inside and outside a window, and across a reset.

// File: rtl/prot_gate.sv
module prot_gate #(
  parameter int KEY_W = 8,
  parameter logic [KEY_W-1:0] KEY_IO  = 8'hD8,
  parameter logic [KEY_W-1:0] KEY_PGM = 8'h9D,
  parameter int WIN_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_we,
  input  logic [KEY_W-1:0] key_wdata,
  input  logic             prot_wr_req,
  input  logic             lock_wr_req,
  input  logic             lock_wr_val,
  input  logic             pgm_req,
  input  logic             irq_in,
  output logic             prot_wr_en,
  output logic             pgm_en,
  output logic             irq_out,
  output logic             pgm_locked
);

  localparam int CNT_W = $clog2(WIN_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WIN_CYC);

  logic [CNT_W-1:0] win_cnt;
  logic             win_pgm;
  logic             win_open, key_io, key_pgm, key_hit, lock_set, accepted;

  assign win_open = (win_cnt != '0);
  assign key_io   = key_we && (key_wdata == KEY_IO);
  assign key_pgm  = key_we && (key_wdata == KEY_PGM);
  assign key_hit  = key_io || key_pgm;

  assign prot_wr_en = prot_wr_req && win_open && !win_pgm;
  assign lock_set   = lock_wr_req && lock_wr_val && win_open && !win_pgm;
  assign pgm_en     = pgm_req && win_open && win_pgm && !pgm_locked;
  assign accepted   = prot_wr_en || lock_set || pgm_en;
  assign irq_out    = irq_in && !win_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
      win_pgm <= 1'b0;
    end else if (key_hit) begin
      win_cnt <= CNT_LOAD;
      win_pgm <= key_pgm;
    end else if (accepted) begin
      win_cnt <= '0;
    end else if (win_open) begin
      win_cnt <= win_cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pgm_locked <= 1'b0;
    else if (lock_set) pgm_locked <= 1'b1;
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> !irq_out); // R6

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_locked |=> pgm_locked); // R9

  AST_NO_PGM_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_locked |-> !pgm_en); // R8

  AST_CLOSE_ON_USE: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && !key_hit) |=> !win_open); // R11

  AST_KEY_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit |=> (win_cnt == CNT_LOAD)); // R10

  AST_WIN_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open && !key_hit && !accepted) |=> (win_cnt == $past(win_cnt) - CNT_W'(1))); // R4

  AST_GRANT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(prot_wr_en && pgm_en)); // R5

endmodule

// File: tb/prot_gate_bench.sv
module prot_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 45;

  // [21]key_we [20:13]key [12]prot [11]lock_req [10]lock_val [9]pgm [8]irq
  // [7]exp_prot [6]exp_pgm [5]exp_irq [4]exp_lock [3:0]requirement
  localparam logic [21:0] VEC [0:NV-1] = '{
    {1'b0,8'h00,5'b10001,4'b0010,4'd5},   // 0  R5 no window
    {1'b0,8'h00,5'b00010,4'b0000,4'd5},   // 1  R5
    {1'b1,8'hD8,5'b00001,4'b0010,4'd2},   // 2  R2 key cycle not yet open
    {1'b0,8'h00,5'b00001,4'b0000,4'd6},   // 3  R6 masked
    {1'b0,8'h00,5'b00010,4'b0000,4'd5},   // 4  R5 wrong kind
    {1'b0,8'h00,5'b00000,4'b0000,4'd2},   // 5
    {1'b0,8'h00,5'b10000,4'b1000,4'd4},   // 6  R4 last open cycle
    {1'b1,8'hD8,5'b00000,4'b0000,4'd4},   // 7
    {1'b0,8'h00,5'b00001,4'b0000,4'd6},   // 8  R6
    {1'b0,8'h00,5'b00001,4'b0000,4'd6},   // 9
    {1'b0,8'h00,5'b00001,4'b0000,4'd6},   // 10
    {1'b0,8'h00,5'b00001,4'b0000,4'd6},   // 11
    {1'b0,8'h00,5'b10001,4'b0010,4'd4},   // 12 R4 expired
    {1'b1,8'h9D,5'b00000,4'b0000,4'd3},   // 13
    {1'b0,8'h00,5'b10000,4'b0000,4'd5},   // 14 R5 wrong kind
    {1'b0,8'h00,5'b00010,4'b0100,4'd3},   // 15 R3 accepted
    {1'b0,8'h00,5'b00011,4'b0010,4'd11},  // 16 R11 closed
    {1'b1,8'hD8,5'b00000,4'b0000,4'd10},  // 17
    {1'b0,8'h00,5'b00000,4'b0000,4'd10},  // 18
    {1'b1,8'h9D,5'b00000,4'b0000,4'd10},  // 19 R10 kind replaced
    {1'b0,8'h00,5'b10000,4'b0000,4'd10},  // 20
    {1'b0,8'h00,5'b00000,4'b0000,4'd10},  // 21
    {1'b0,8'h00,5'b00000,4'b0000,4'd10},  // 22
    {1'b0,8'h00,5'b00010,4'b0100,4'd10},  // 23 R10 count restarted
    {1'b1,8'hD8,5'b00000,4'b0000,4'd2},   // 24
    {1'b0,8'h00,5'b10000,4'b1000,4'd2},   // 25 R2
    {1'b0,8'h00,5'b10000,4'b0000,4'd11},  // 26 R11
    {1'b1,8'h55,5'b00001,4'b0010,4'd12},  // 27 R12
    {1'b0,8'h00,5'b10001,4'b0010,4'd12},  // 28
    {1'b1,8'hD8,5'b00000,4'b0000,4'd12},  // 29
    {1'b1,8'h55,5'b00001,4'b0000,4'd12},  // 30 bad key mid window
    {1'b0,8'h00,5'b00000,4'b0000,4'd12},  // 31
    {1'b0,8'h00,5'b00000,4'b0000,4'd12},  // 32
    {1'b0,8'h00,5'b00001,4'b0000,4'd12},  // 33 still open
    {1'b0,8'h00,5'b10001,4'b0010,4'd12},  // 34 not restarted
    {1'b0,8'h00,5'b01100,4'b0000,4'd7},   // 35 R7 lock outside window
    {1'b1,8'hD8,5'b00000,4'b0000,4'd7},   // 36
    {1'b0,8'h00,5'b01000,4'b0000,4'd9},   // 37 R9 write zero
    {1'b0,8'h00,5'b01100,4'b0000,4'd7},   // 38 R7 lock set
    {1'b0,8'h00,5'b00001,4'b0011,4'd11},  // 39 R11 closed, locked
    {1'b1,8'h9D,5'b00000,4'b0001,4'd8},   // 40
    {1'b0,8'h00,5'b00010,4'b0001,4'd8},   // 41 R8 refused
    {1'b1,8'hD8,5'b00000,4'b0001,4'd9},   // 42
    {1'b0,8'h00,5'b01000,4'b0001,4'd9},   // 43
    {1'b0,8'h00,5'b00000,4'b0001,4'd9}    // 44 R9 still locked
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key_we = 1'b0;
  logic [7:0] key_wdata = '0;
  logic prot_wr_req = 1'b0, lock_wr_req = 1'b0, lock_wr_val = 1'b0;
  logic pgm_req = 1'b0, irq_in = 1'b0;
  logic prot_wr_en, pgm_en, irq_out, pgm_locked;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prot_gate u_prot_gate (
    .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_wdata(key_wdata),
    .prot_wr_req(prot_wr_req), .lock_wr_req(lock_wr_req), .lock_wr_val(lock_wr_val),
    .pgm_req(pgm_req), .irq_in(irq_in),
    .prot_wr_en(prot_wr_en), .pgm_en(pgm_en), .irq_out(irq_out), .pgm_locked(pgm_locked)
  );

  task automatic check(input string name, input int req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%b expected=%b", req, name, act, exp);
    end
  endtask

  task automatic drive(input logic kwe, input logic [7:0] k, input logic [4:0] ctl);
    key_we = kwe; key_wdata = k;
    {prot_wr_req, lock_wr_req, lock_wr_val, pgm_req, irq_in} = ctl;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][21], VEC[i][20:13], VEC[i][12:8]);
      #1;
      check($sformatf("vec%0d prot_wr_en", i), int'(VEC[i][3:0]), prot_wr_en, VEC[i][7]);
      check($sformatf("vec%0d pgm_en", i),     int'(VEC[i][3:0]), pgm_en,     VEC[i][6]);
      check($sformatf("vec%0d irq_out", i),    int'(VEC[i][3:0]), irq_out,    VEC[i][5]);
      check($sformatf("vec%0d pgm_locked", i), int'(VEC[i][3:0]), pgm_locked, VEC[i][4]);
      @(negedge clk);
    end

    // R1 / R9: reset clears the lock and any window
    drive(1'b1, 8'hD8, 5'b00000);
    @(negedge clk);
    drive(1'b0, 8'h00, 5'b10011);
    rst_n = 1'b0;
    #1;
    check("reset pgm_locked", 1, pgm_locked, 1'b0);
    check("reset prot_wr_en", 1, prot_wr_en, 1'b0);
    check("reset pgm_en", 1, pgm_en, 1'b0);
    check("reset irq passes", 1, irq_out, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("after reset no window", 1, prot_wr_en, 1'b0);
    @(negedge clk);
    drive(1'b1, 8'h9D, 5'b00000);
    @(negedge clk);
    drive(1'b0, 8'h00, 5'b00010);
    #1;
    check("R9 program allowed after reset", 9, pgm_en, 1'b1);
    @(negedge clk);
    drive(1'b0, 8'h00, 5'b00000);
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule